// File: doc/BRIEF.md
# Self-Healing Fault Diagnosis Controller

This block runs the repair policy for a region protected by triplicated modules and triplicated voters. It keeps requesting scan captures of every module and voter output. When the replicas disagree, it works out whether the upset was a passing register flip, a corrupted configuration cell, or a lasting defect in the fabric, and then asks the neighbouring subsystems to act. Every other subsystem sits behind a plain request/acknowledge pair: scan capture, scan chain self-check, configuration readback with compare, partial rewrite (scrub), module relocation, and test of a vacated area.

The snapshot is made of one six-bit group per protected function. Bits 0 to 2 of a group are the three module replicas. Bits 3 to 5 are the three voter copies. A cell is failing when it differs from the majority of the three module bits in its group. A burst of adjacent failing cells points at the scan chain rather than the modules, so the chain is checked first. The spare pool holds a small number of relocation slots. A slot whose released area fails its test goes into a faulty map and is never handed out again.

Top module: `self_heal_diag`

## Requirements
- R1: After reset the block requests a scan capture (`cap_req`=1). No other request is high, `done` is 0, both sticky flags are 0 and `faulty_map` is all zero.
- R2: A snapshot with no failing cell starts no diagnosis. The block keeps `cap_req` high for the next capture and does not pulse `done`.
- R3: A failing module cell (group bit 0..2) leads to exactly one recapture. If that cell is clean in the recapture, `done` pulses with class 1 (transient) and no readback is requested.
- R4: A failing voter cell (group bit 3..5) skips the recapture. The readback request follows the capture acknowledge directly.
- R5: A fault that persists leads to a readback request. On `rb_match`=0 the block requests a scrub and then a verify capture. A clean verify ends with class 2 (scrubbed).
- R6: On `rb_match`=1 the fault is permanent. Relocation is requested to the lowest free spare slot (`reloc_slot`), then a test of the released area follows. The sequence ends with class 3 (relocated).
- R7: A verify capture that still shows the target cell failing after a scrub escalates to the relocation path.
- R8: A passing area test (`test_pass`=1) returns the slot to the pool. A failing test sets that slot's bit in `faulty_map`, and the slot is never offered again.
- R9: Three or more adjacent failing cells anywhere in the snapshot request a chain check before any diagnosis. `chk_ok`=0 ends with class 5 (chain fault). `chk_ok`=1 goes on to diagnose the lowest failing cell.
- R10: When relocation is needed and no slot is free, `done` pulses with class 4 (no spare), `out_of_spares` is set and stays set, and no relocation is requested.
- R11: A request left without acknowledge for 1024 cycles is dropped. `done` pulses with class 6 (timeout), and `timeout_err` is set and stays set.
- R12: At most one request is high at a time. `done` lasts one cycle, and during it `tgt_cell` holds the index of the lowest failing snapshot cell from the capture that started the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_req | output | 1 | Scan capture request |
| cap_ack | input | 1 | Capture done; `snap_data` valid |
| snap_data | input | 24 | Captured module/voter outputs, 6 bits per function |
| chk_req | output | 1 | Scan chain self-check request |
| chk_ack | input | 1 | Chain check done |
| chk_ok | input | 1 | Chain check result, 1 = chain healthy |
| rb_req | output | 1 | Configuration readback and compare request |
| rb_ack | input | 1 | Readback done |
| rb_match | input | 1 | 1 = configuration equals golden copy |
| scrub_req | output | 1 | Partial rewrite request for the target area |
| scrub_ack | input | 1 | Rewrite done |
| reloc_req | output | 1 | Module relocation request |
| reloc_ack | input | 1 | Relocation done |
| reloc_slot | output | 3 | Spare slot chosen for relocation |
| test_req | output | 1 | Test request for the released area |
| test_ack | input | 1 | Test done |
| test_pass | input | 1 | 1 = released area healthy |
| tgt_cell | output | 5 | Snapshot cell under diagnosis |
| done | output | 1 | One-cycle end-of-sequence pulse |
| done_class | output | 3 | Outcome code, valid with `done` |
| faulty_map | output | 8 | Slots retired as defective |
| out_of_spares | output | 1 | Sticky: relocation needed with no slot left |
| timeout_err | output | 1 | Sticky: a handshake timed out |

## Verification
A wrong internal state shows up at the request pins within one cycle of the acknowledge that should have moved it. A missing or extra recapture shows up as a wrong number of `cap_req` services before `rb_req`, and a wrong path shows up as a request that should never have been raised (scrub, relocate, chain check). Spare-pool corruption shows up at the next relocation as a wrong `reloc_slot`, or as a `faulty_map` bit that appears, clears or never sets. The class and target on the single `done` cycle then confirm the decision that was taken.

// File: rtl/shd_pkg.sv
package shd_pkg;

    typedef enum logic [3:0] {
        ST_SCAN,
        ST_CHAIN,
        ST_RECAP,
        ST_RDBK,
        ST_SCRUB,
        ST_VERIFY,
        ST_RELOC,
        ST_TEST,
        ST_DONE
    } shd_state_e;

    typedef enum logic [2:0] {
        CL_NONE      = 3'd0,
        CL_TRANSIENT = 3'd1,
        CL_SCRUBBED  = 3'd2,
        CL_RELOCATED = 3'd3,
        CL_NO_SPARE  = 3'd4,
        CL_CHAIN     = 3'd5,
        CL_TIMEOUT   = 3'd6
    } shd_class_e;

    // cells per protected function: three replicas, then three voters
    localparam int CELLS_PER_FUNC = 6;
    localparam int VOTER_BASE     = 3;

endpackage

// File: rtl/shd_snap_eval.sv
module shd_snap_eval
    import shd_pkg::*;
#(
    parameter int NUM_FUNC = 4,
    parameter int RUN_LEN  = 3,
    localparam int SNAP_W  = NUM_FUNC * CELLS_PER_FUNC,
    localparam int CW      = $clog2(SNAP_W)
) (
    input  logic [SNAP_W-1:0] snap,
    output logic [SNAP_W-1:0] fail_vec,
    output logic              any_fail,
    output logic              run_hit,
    output logic [CW-1:0]     first_idx,
    output logic              first_voter
);

    // per-function majority of the replicas; each cell compared against it
    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
        localparam int BASE = f * CELLS_PER_FUNC;
        logic ra, rb, rc, maj;
        assign ra  = snap[BASE];
        assign rb  = snap[BASE + 1];
        assign rc  = snap[BASE + 2];
        assign maj = (ra & rb) | (ra & rc) | (rb & rc);
        for (genvar k = 0; k < CELLS_PER_FUNC; k++) begin : g_cell
            assign fail_vec[BASE + k] = snap[BASE + k] ^ maj;
        end
    end

    assign any_fail = |fail_vec;

    // a burst of adjacent failures anywhere in the chain
    always_comb begin
        run_hit = 1'b0;
        for (int i = 0; i <= SNAP_W - RUN_LEN; i++) begin
            if (&fail_vec[i +: RUN_LEN]) run_hit = 1'b1;
        end
    end

    // lowest failing cell wins
    always_comb begin
        first_idx   = '0;
        first_voter = 1'b0;
        for (int i = SNAP_W - 1; i >= 0; i--) begin
            if (fail_vec[i]) begin
                first_idx   = CW'(i);
                first_voter = ((i % CELLS_PER_FUNC) >= VOTER_BASE);
            end
        end
    end

endmodule

// File: rtl/shd_spare_pool.sv
module shd_spare_pool #(
    parameter int NUM_SPARE = 8,
    localparam int SW       = $clog2(NUM_SPARE)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 claim,
    input  logic                 give_back,
    input  logic                 retire,
    input  logic [SW-1:0]        slot,
    output logic                 have_free,
    output logic [SW-1:0]        pick,
    output logic [NUM_SPARE-1:0] faulty_map
);

    typedef struct packed {
        logic [NUM_SPARE-1:0] free;
        logic [NUM_SPARE-1:0] bad;
    } pool_t;

    pool_t p_q, p_d;

    always_comb begin
        p_d = p_q;
        if (claim)     p_d.free[slot] = 1'b0;
        if (give_back) p_d.free[slot] = 1'b1;
        if (retire)    p_d.bad[slot]  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q.free <= {NUM_SPARE{1'b1}};
            p_q.bad  <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    always_comb begin
        pick = '0;
        for (int i = NUM_SPARE - 1; i >= 0; i--) begin
            if (p_q.free[i]) pick = SW'(i);
        end
    end

    assign have_free  = |p_q.free;
    assign faulty_map = p_q.bad;

    AST_CLAIM_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> p_q.free[slot]);                                           // R8
    AST_RETIRED_NOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(p_q.free & p_q.bad)));                                           // R8
    AST_RETIRED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((p_q.bad & $past(p_q.bad)) == $past(p_q.bad)));             // R8

endmodule

// File: rtl/shd_hs_timer.sv
module shd_hs_timer #(
    parameter int LIMIT = 1024,
    localparam int TW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic waiting,
    input  logic ack,
    output logic expired
);

    logic [TW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = '0;
        if (waiting && !ack && !expired) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = waiting && !ack && (cnt_q == TW'(LIMIT - 1));

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TW'(LIMIT - 1));                                            // R11

endmodule

// File: rtl/self_heal_diag.sv
module self_heal_diag
    import shd_pkg::*;
#(
    parameter int NUM_FUNC    = 4,
    parameter int RUN_LEN     = 3,
    parameter int NUM_SPARE   = 8,
    parameter int TIMEOUT_CYC = 1024,
    localparam int SNAP_W     = NUM_FUNC * CELLS_PER_FUNC,
    localparam int CW         = $clog2(SNAP_W),
    localparam int SW         = $clog2(NUM_SPARE)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 cap_req,
    input  logic                 cap_ack,
    input  logic [SNAP_W-1:0]    snap_data,
    output logic                 chk_req,
    input  logic                 chk_ack,
    input  logic                 chk_ok,
    output logic                 rb_req,
    input  logic                 rb_ack,
    input  logic                 rb_match,
    output logic                 scrub_req,
    input  logic                 scrub_ack,
    output logic                 reloc_req,
    input  logic                 reloc_ack,
    output logic [SW-1:0]        reloc_slot,
    output logic                 test_req,
    input  logic                 test_ack,
    input  logic                 test_pass,
    output logic [CW-1:0]        tgt_cell,
    output logic                 done,
    output logic [2:0]           done_class,
    output logic [NUM_SPARE-1:0] faulty_map,
    output logic                 out_of_spares,
    output logic                 timeout_err
);

    typedef struct packed {
        shd_state_e    st;
        shd_class_e    cls;
        logic [CW-1:0] tgt;
        logic          voter;
        logic [SW-1:0] slot;
        logic          oos;
        logic          terr;
    } ctl_t;

    ctl_t c_q, c_d;

    // ---------------- snapshot evaluation ----------------
    logic [SNAP_W-1:0] ev_fail;
    logic              ev_any, ev_run, ev_voter;
    logic [CW-1:0]     ev_first;

    shd_snap_eval #(.NUM_FUNC(NUM_FUNC), .RUN_LEN(RUN_LEN)) u_eval (
        .snap        (snap_data),
        .fail_vec    (ev_fail),
        .any_fail    (ev_any),
        .run_hit     (ev_run),
        .first_idx   (ev_first),
        .first_voter (ev_voter)
    );

    // ---------------- spare pool ----------------
    logic          pool_claim, pool_give, pool_retire, pool_free;
    logic [SW-1:0] pool_pick;

    shd_spare_pool #(.NUM_SPARE(NUM_SPARE)) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .claim      (pool_claim),
        .give_back  (pool_give),
        .retire     (pool_retire),
        .slot       (c_q.slot),
        .have_free  (pool_free),
        .pick       (pool_pick),
        .faulty_map (faulty_map)
    );

    // ---------------- handshake watchdog ----------------
    logic cur_ack, hs_waiting, hs_expired;

    always_comb begin
        unique case (c_q.st)
            ST_SCAN, ST_RECAP, ST_VERIFY: cur_ack = cap_ack;
            ST_CHAIN:                     cur_ack = chk_ack;
            ST_RDBK:                      cur_ack = rb_ack;
            ST_SCRUB:                     cur_ack = scrub_ack;
            ST_RELOC:                     cur_ack = reloc_ack;
            ST_TEST:                      cur_ack = test_ack;
            default:                      cur_ack = 1'b0;
        endcase
    end

    assign hs_waiting = (c_q.st != ST_DONE);

    shd_hs_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .waiting (hs_waiting),
        .ack     (cur_ack),
        .expired (hs_expired)
    );

    // ---------------- next-state logic ----------------
    logic tgt_still_bad;
    assign tgt_still_bad = ev_fail[c_q.tgt];

    assign pool_claim  = (c_q.st == ST_RELOC) && reloc_ack;
    assign pool_give   = (c_q.st == ST_TEST) && test_ack && test_pass;
    assign pool_retire = (c_q.st == ST_TEST) && test_ack && !test_pass;

    always_comb begin
        c_d = c_q;
        if (hs_expired) begin
            c_d.st   = ST_DONE;
            c_d.cls  = CL_TIMEOUT;
            c_d.terr = 1'b1;
        end else begin
            unique case (c_q.st)
                ST_SCAN: begin
                    if (cap_ack && ev_any) begin
                        c_d.tgt   = ev_first;
                        c_d.voter = ev_voter;
                        if (ev_run)        c_d.st = ST_CHAIN;
                        else if (ev_voter) c_d.st = ST_RDBK;
                        else               c_d.st = ST_RECAP;
                    end
                end
                ST_CHAIN: begin
                    if (chk_ack) begin
                        if (!chk_ok) begin
                            c_d.st  = ST_DONE;
                            c_d.cls = CL_CHAIN;
                        end else begin
                            c_d.st = c_q.voter ? ST_RDBK : ST_RECAP;
                        end
                    end
                end
                ST_RECAP: begin
                    if (cap_ack) begin
                        if (tgt_still_bad) begin
                            c_d.st = ST_RDBK;
                        end else begin
                            c_d.st  = ST_DONE;
                            c_d.cls = CL_TRANSIENT;
                        end
                    end
                end
                ST_RDBK: begin
                    if (rb_ack) begin
                        if (!rb_match) begin
                            c_d.st = ST_SCRUB;
                        end else if (pool_free) begin
                            c_d.st   = ST_RELOC;
                            c_d.slot = pool_pick;
                        end else begin
                            c_d.st  = ST_DONE;
                            c_d.cls = CL_NO_SPARE;
                            c_d.oos = 1'b1;
                        end
                    end
                end
                ST_SCRUB: begin
                    if (scrub_ack) c_d.st = ST_VERIFY;
                end
                ST_VERIFY: begin
                    if (cap_ack) begin
                        if (!tgt_still_bad) begin
                            c_d.st  = ST_DONE;
                            c_d.cls = CL_SCRUBBED;
                        end else if (pool_free) begin
                            c_d.st   = ST_RELOC;
                            c_d.slot = pool_pick;
                        end else begin
                            c_d.st  = ST_DONE;
                            c_d.cls = CL_NO_SPARE;
                            c_d.oos = 1'b1;
                        end
                    end
                end
                ST_RELOC: begin
                    if (reloc_ack) c_d.st = ST_TEST;
                end
                ST_TEST: begin
                    if (test_ack) begin
                        c_d.st  = ST_DONE;
                        c_d.cls = CL_RELOCATED;
                    end
                end
                ST_DONE: begin
                    c_d.st  = ST_SCAN;
                    c_d.cls = CL_NONE;
                end
                default: c_d.st = ST_SCAN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.st    <= ST_SCAN;
            c_q.cls   <= CL_NONE;
            c_q.tgt   <= '0;
            c_q.voter <= 1'b0;
            c_q.slot  <= '0;
            c_q.oos   <= 1'b0;
            c_q.terr  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    // ---------------- outputs ----------------
    assign cap_req       = (c_q.st == ST_SCAN) || (c_q.st == ST_RECAP) || (c_q.st == ST_VERIFY);
    assign chk_req       = (c_q.st == ST_CHAIN);
    assign rb_req        = (c_q.st == ST_RDBK);
    assign scrub_req     = (c_q.st == ST_SCRUB);
    assign reloc_req     = (c_q.st == ST_RELOC);
    assign test_req      = (c_q.st == ST_TEST);
    assign reloc_slot    = c_q.slot;
    assign tgt_cell      = c_q.tgt;
    assign done          = (c_q.st == ST_DONE);
    assign done_class    = c_q.cls;
    assign out_of_spares = c_q.oos;
    assign timeout_err   = c_q.terr;

    // ---------------- assertions ----------------
    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_req, chk_req, rb_req, scrub_req, reloc_req, test_req}));         // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                                  // R12
    AST_VOTER_SKIPS_RECAP: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_SCAN && cap_ack && ev_any && !ev_run && ev_voter) |=> rb_req);      // R4
    AST_BURST_CHECKS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_SCAN && cap_ack && ev_run) |=> chk_req);                           // R9
    AST_RELOC_HAS_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
        reloc_req |-> pool_free);                                                         // R10
    AST_OOS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_spares |=> out_of_spares);                                                 // R10
    AST_TERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> timeout_err);                                                     // R11
    AST_SCRUB_THEN_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
        (scrub_req && scrub_ack) |=> cap_req);                                            // R5

endmodule

// File: tb/sim_self_heal_diag.sv
module sim_self_heal_diag;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_req, chk_req, rb_req, scrub_req, reloc_req, test_req;
    logic        cap_ack = 0, chk_ack = 0, rb_ack = 0, scrub_ack = 0, reloc_ack = 0, test_ack = 0;
    logic        chk_ok = 0, rb_match = 0, test_pass = 0;
    logic [23:0] snap_data = '0;
    logic [2:0]  reloc_slot;
    logic [4:0]  tgt_cell;
    logic        done;
    logic [2:0]  done_class;
    logic [7:0]  faulty_map;
    logic        out_of_spares, timeout_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    self_heal_diag u0 (
        .clk(clk), .rst_n(rst_n),
        .cap_req(cap_req), .cap_ack(cap_ack), .snap_data(snap_data),
        .chk_req(chk_req), .chk_ack(chk_ack), .chk_ok(chk_ok),
        .rb_req(rb_req), .rb_ack(rb_ack), .rb_match(rb_match),
        .scrub_req(scrub_req), .scrub_ack(scrub_ack),
        .reloc_req(reloc_req), .reloc_ack(reloc_ack), .reloc_slot(reloc_slot),
        .test_req(test_req), .test_ack(test_ack), .test_pass(test_pass),
        .tgt_cell(tgt_cell), .done(done), .done_class(done_class),
        .faulty_map(faulty_map), .out_of_spares(out_of_spares), .timeout_err(timeout_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic void finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // serves every handshake until done; single-cycle acks
    task automatic serve(input logic [23:0] s0, input logic [23:0] s1, input logic [23:0] s2,
                         input logic ck, input logic rm, input logic tp, input bit hang_rb,
                         output int cls, output int tgt, output int caps, output int chk,
                         output int rb, output int rl, output int slot);
        logic [23:0] snaps [3];
        bit fin = 0;
        snaps[0] = s0; snaps[1] = s1; snaps[2] = s2;
        cls = -1; tgt = -1; caps = 0; chk = 0; rb = 0; rl = 0; slot = -1;
        chk_ok = ck; rb_match = rm; test_pass = tp;
        for (int n = 0; n < 3000 && !fin; n++) begin
            @(negedge clk);
            {cap_ack, chk_ack, rb_ack, scrub_ack, reloc_ack, test_ack} = '0;
            if (done) begin
                fin = 1; cls = done_class; tgt = tgt_cell;
            end else if (cap_req) begin
                snap_data = snaps[caps < 3 ? caps : 2]; caps++; cap_ack = 1;
            end else if (chk_req) begin
                chk++; chk_ack = 1;
            end else if (rb_req) begin
                if (rb == 0 || !hang_rb) rb++;
                if (!hang_rb) rb_ack = 1;
            end else if (scrub_req) begin
                scrub_ack = 1;
            end else if (reloc_req) begin
                rl++; slot = reloc_slot; reloc_ack = 1;
            end else if (test_req) begin
                test_ack = 1;
            end
        end
    endtask

    typedef struct packed {
        logic [23:0] s0, s1, s2;
        logic        ck, rm, tp;
        logic [2:0]  cls;
        logic [4:0]  tgt;
        logic [1:0]  caps;
        logic        chk, rb, rl;
        logic [2:0]  slot;
        logic [7:0]  faulty;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{24'h000080, 24'h0,      24'h0,      1'b1, 1'b0, 1'b0, 3'd1, 5'd7,  2'd2, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00},
        '{24'h000EC0, 24'h0,      24'h0,      1'b1, 1'b0, 1'b0, 3'd1, 5'd8,  2'd2, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00},
        '{24'h001000, 24'h001000, 24'h0,      1'b1, 1'b0, 1'b0, 3'd2, 5'd12, 2'd3, 1'b0, 1'b1, 1'b0, 3'd0, 8'h00},
        '{24'h400000, 24'h0,      24'h0,      1'b1, 1'b0, 1'b0, 3'd2, 5'd22, 2'd2, 1'b0, 1'b1, 1'b0, 3'd0, 8'h00},
        '{24'h000004, 24'h000004, 24'h0,      1'b1, 1'b1, 1'b1, 3'd3, 5'd2,  2'd2, 1'b0, 1'b1, 1'b1, 3'd0, 8'h00},
        '{24'h002000, 24'h002000, 24'h002000, 1'b1, 1'b0, 1'b0, 3'd3, 5'd13, 2'd3, 1'b0, 1'b1, 1'b1, 3'd0, 8'h01},
        '{24'h00001C, 24'h0,      24'h0,      1'b0, 1'b0, 1'b0, 3'd5, 5'd2,  2'd1, 1'b1, 1'b0, 1'b0, 3'd0, 8'h01},
        '{24'h00001C, 24'h0,      24'h0,      1'b1, 1'b0, 1'b0, 3'd1, 5'd2,  2'd2, 1'b1, 1'b0, 1'b0, 3'd0, 8'h01}
    };

    initial begin
        string vtag [NV] = '{"R3", "R3", "R5", "R4", "R6", "R7", "R9", "R9"};
        int cls, tgt, caps, chk, rb, rl, slot;

        do_reset();
        // R1 reset state
        check(cap_req === 1'b1, "R1 cap_req", cap_req, 1);
        check({chk_req, rb_req, scrub_req, reloc_req, test_req} === 5'b0, "R1 other reqs",
              {chk_req, rb_req, scrub_req, reloc_req, test_req}, 0);
        check({done, out_of_spares, timeout_err} === 3'b0, "R1 flags",
              {done, out_of_spares, timeout_err}, 0);
        check(faulty_map === 8'h00, "R1 faulty_map", faulty_map, 0);

        // R2 clean snapshot: no action, capture again
        snap_data = 24'h0; cap_ack = 1;
        @(negedge clk); cap_ack = 0;
        for (int k = 0; k < 3; k++) begin
            check(!done && !chk_req && !rb_req && cap_req, "R2 clean snapshot idle",
                  {done, chk_req, rb_req, cap_req}, 1);
            @(negedge clk);
        end
        // all-ones agreement is clean too
        snap_data = 24'hFFFFFF; cap_ack = 1;
        @(negedge clk); cap_ack = 0;
        check(!done && cap_req && !rb_req, "R2 all-ones clean", {done, cap_req, rb_req}, 2);

        // vector table
        for (int v = 0; v < NV; v++) begin
            serve(VEC[v].s0, VEC[v].s1, VEC[v].s2, VEC[v].ck, VEC[v].rm, VEC[v].tp, 1'b0,
                  cls, tgt, caps, chk, rb, rl, slot);
            check(cls == int'(VEC[v].cls), {vtag[v], " class"}, cls, VEC[v].cls);
            check(tgt == int'(VEC[v].tgt), "R12 target cell", tgt, VEC[v].tgt);
            check(caps == int'(VEC[v].caps), {vtag[v], " captures"}, caps, VEC[v].caps);
            check(chk == int'(VEC[v].chk), "R9 chain check count", chk, VEC[v].chk);
            check(rb == int'(VEC[v].rb), {vtag[v], " readback count"}, rb, VEC[v].rb);
            check(rl == int'(VEC[v].rl), "R6 relocation count", rl, VEC[v].rl);
            if (VEC[v].rl) check(slot == int'(VEC[v].slot), "R6 relocation slot", slot, VEC[v].slot);
            @(negedge clk);
            check(faulty_map == VEC[v].faulty, "R8 faulty map", faulty_map, VEC[v].faulty);
        end

        // R8 / R10: retire the remaining slots one by one
        for (int i = 1; i < 8; i++) begin
            serve(24'h4, 24'h4, 24'h0, 1'b1, 1'b1, 1'b0, 1'b0, cls, tgt, caps, chk, rb, rl, slot);
            check(cls == 3, "R6 relocated class", cls, 3);
            check(slot == i, "R8 retired slot not reused", slot, i);
            @(negedge clk);
            check(faulty_map == 8'((1 << (i + 1)) - 1), "R8 faulty map grows",
                  faulty_map, (1 << (i + 1)) - 1);
        end
        check(out_of_spares === 1'b0, "R10 flag low while spares left", out_of_spares, 0);
        serve(24'h4, 24'h4, 24'h0, 1'b1, 1'b1, 1'b0, 1'b0, cls, tgt, caps, chk, rb, rl, slot);
        check(cls == 4, "R10 no-spare class", cls, 4);
        check(rl == 0, "R10 no relocation request", rl, 0);
        @(negedge clk);
        check(out_of_spares === 1'b1, "R10 flag set", out_of_spares, 1);
        // sticky across a later transient sequence
        serve(24'h80, 24'h0, 24'h0, 1'b1, 1'b0, 1'b0, 1'b0, cls, tgt, caps, chk, rb, rl, slot);
        check(cls == 1 && out_of_spares === 1'b1, "R10 flag sticky", out_of_spares, 1);

        // R11 timeout on an unanswered readback
        do_reset();
        check(out_of_spares === 1'b0 && faulty_map === 8'h00, "R1 reset clears state",
              {out_of_spares, faulty_map}, 0);
        serve(24'h4, 24'h4, 24'h0, 1'b1, 1'b1, 1'b1, 1'b1, cls, tgt, caps, chk, rb, rl, slot);
        check(cls == 6, "R11 timeout class", cls, 6);
        check(rb == 1 && rl == 0, "R11 sequence aborted", rl, 0);
        @(negedge clk);
        check(timeout_err === 1'b1, "R11 timeout flag", timeout_err, 1);
        check(rb_req === 1'b0 && cap_req === 1'b1, "R11 request dropped", rb_req, 0);
        repeat (5) @(negedge clk);
        check(timeout_err === 1'b1, "R11 timeout flag sticky", timeout_err, 1);

        finish_run();
    end

endmodule